// File: doc/BRIEF.md
# Programmable Square-Noise Sound Generator

This block makes a mono audio sample from four voices. Three voices are square-wave tone generators, each with a programmable 10-bit half-period. The fourth voice is a noise source built on a 16-bit shift register. The noise can run in a white (pseudo-random) mode or in a periodic mode. Its shift clock comes either from one of three fixed dividers or from the rising edges of the third tone voice. Every voice has a 4-bit attenuator in 2 dB steps. The levels of all voices whose output is currently high are added into one unsigned sample.

The host programs the block one byte at a time. A byte with the top bit set selects a voice and a register, and carries four data bits. A byte with the top bit clear carries the upper six period bits for the tone period selected last. All counters advance only on cycles where the prescale tick is high.

A tone whose period is 0 or 1 holds its output high. While that holds, each volume write sets the output level directly, so the host can play samples by streaming attenuation values.

Top module: `sqn_sound_gen`

## Requirements
- R1: After reset, `sample_out` is 0. All attenuators read 15 (silent), all periods read 0, all tone outputs are high, the noise register holds its seed, and the noise setting is periodic with rate 0.
- R2: A byte with bit 7 = 1 is a latch byte. Bits 6:5 pick the voice: 0, 1 and 2 are the tones and 3 is the noise. Bit 4 picks the register: 1 = attenuation, 0 = period (or noise control for voice 3). Bits 3:0 give the attenuation or the low four period bits. The voice and register are remembered.
- R3: A byte with bit 7 = 0 writes its bits 5:0 into period bits 9:4 of the remembered tone. When the remembered register is an attenuation or the noise control, the byte is ignored.
- R4: For a period P ≥ 2, a tone output toggles once every P ticks, and it never changes on a cycle without a tick.
- R5: With a period of 0 or 1, the tone output is forced high on every tick.
- R6: An attenuation a gives a level of round(255·10^(−a/10)), accurate to ±1. Attenuation 0 gives exactly 255, and attenuation 15 gives 0.
- R7: One clock edge after any cycle, `sample_out` equals the sum of the levels of the voices whose output was high in that cycle.
- R8: Noise control bit 2 = 1 selects white mode. Each shift moves the register right by one and feeds bit0 XOR bit3 into bit 15. The noise output is bit 0.
- R9: Noise control bit 2 = 0 selects periodic mode. Each shift feeds bit 0 back into bit 15.
- R10: Noise control bits 1:0 = r, for r = 0, 1 or 2, shift once every NOISE_BASE·2^r ticks. The first shift comes on the first tick after the control write.
- R11: Noise control bits 1:0 = 3 shift the register one cycle after each low-to-high transition of tone 2, whatever the tick.
- R12: Any write to the noise control reloads the register with 0x8000 and restarts the fixed divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescale tick; counters advance when high |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Latch or data byte |
| sample_out | output | LVL_W+2 | Registered unsigned mono sample |

## Verification
The bench builds the block with PERIOD_W = 10, ATT_W = 4 and LVL_W = 8. It lowers NOISE_BASE to 4, so that all three fixed noise rates run through many shifts and full periodic cycles within a few hundred ticks. With the full 10-bit period kept, random writes reach both very long and held tone periods. Gaps in the tick input and writes that land on tick cycles show that every counter is gated by the tick, and that the noise voice can follow tone 2 in its own timing.

// File: rtl/sqn_pkg.sv
package sqn_pkg;
  localparam int NUM_TONES = 3;
  localparam int NUM_CH    = 4;
  localparam int NOISE_CH  = 3;

  typedef enum logic {
    REG_PERIOD = 1'b0,
    REG_ATTEN  = 1'b1
  } reg_kind_e;

  // Level for one attenuation step count: full scale times 0.79433^att
  // (2 dB per step), computed in 16-bit fixed point; the top code is silent.
  function automatic int att_level(input int att, input int silent, input int amp_w);
    logic [63:0] acc;
    acc = ((64'd1 << amp_w) - 64'd1) << 16;
    for (int i = 1; i < 64; i++) begin
      if (i <= att) acc = (acc * 64'd52057) >> 16;
    end
    if (att >= silent) return 0;
    return int'((acc + 64'd32768) >> 16);
  endfunction
endpackage

// File: rtl/sqn_regs.sv
module sqn_regs #(
  parameter int PERIOD_W = 10,
  parameter int ATT_W    = 4
) (
  input  logic                                            clk,
  input  logic                                            rst_n,
  input  logic                                            wr_en,
  input  logic [7:0]                                      wr_data,
  output logic [sqn_pkg::NUM_TONES-1:0][PERIOD_W-1:0]     period_q,
  output logic [sqn_pkg::NUM_CH-1:0][ATT_W-1:0]           att_q,
  output logic                                            noise_white,
  output logic [1:0]                                      noise_rate,
  output logic                                            noise_load
);
  import sqn_pkg::*;

  localparam int HI_W = PERIOD_W - 4;

  logic [NUM_TONES-1:0][PERIOD_W-1:0] period_n;
  logic [NUM_CH-1:0][ATT_W-1:0]       att_n;
  logic                               white_n;
  logic [1:0]                         rate_n;
  logic [1:0]                         sel_q, sel_n;
  reg_kind_e                          kind_q, kind_n;

  always_comb begin
    period_n   = period_q;
    att_n      = att_q;
    white_n    = noise_white;
    rate_n     = noise_rate;
    sel_n      = sel_q;
    kind_n     = kind_q;
    noise_load = 1'b0;
    if (wr_en) begin
      if (wr_data[7]) begin
        sel_n  = wr_data[6:5];
        kind_n = reg_kind_e'(wr_data[4]);
        if (wr_data[4]) begin
          att_n[wr_data[6:5]] = wr_data[ATT_W-1:0];
        end else if (wr_data[6:5] == 2'(NOISE_CH)) begin
          white_n    = wr_data[2];
          rate_n     = wr_data[1:0];
          noise_load = 1'b1;
        end else begin
          for (int c = 0; c < NUM_TONES; c++) begin
            if (wr_data[6:5] == 2'(c)) period_n[c][3:0] = wr_data[3:0];
          end
        end
      end else if (kind_q == REG_PERIOD && sel_q != 2'(NOISE_CH)) begin
        for (int c = 0; c < NUM_TONES; c++) begin
          if (sel_q == 2'(c)) period_n[c][PERIOD_W-1:4] = wr_data[HI_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q    <= '0;
      att_q       <= '1;
      noise_white <= 1'b0;
      noise_rate  <= 2'd0;
      sel_q       <= 2'd0;
      kind_q      <= REG_PERIOD;
    end else begin
      period_q    <= period_n;
      att_q       <= att_n;
      noise_white <= white_n;
      noise_rate  <= rate_n;
      sel_q       <= sel_n;
      kind_q      <= kind_n;
    end
  end
endmodule

// File: rtl/sqn_tone.sv
module sqn_tone #(
  parameter int PERIOD_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic [PERIOD_W-1:0] period,
  output logic                tone_out
);
  logic [PERIOD_W-1:0] cnt_q, cnt_n;
  logic                out_n;
  logic                held;

  assign held = (period <= PERIOD_W'(1));

  always_comb begin
    cnt_n = cnt_q;
    out_n = tone_out;
    if (tick_en) begin
      if (held) begin
        cnt_n = '0;
        out_n = 1'b1;
      end else if (cnt_q <= PERIOD_W'(1)) begin
        cnt_n = period;
        out_n = ~tone_out;
      end else begin
        cnt_n = cnt_q - PERIOD_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      tone_out <= 1'b1;
    end else begin
      cnt_q    <= cnt_n;
      tone_out <= out_n;
    end
  end
endmodule

// File: rtl/sqn_noise.sv
module sqn_noise #(
  parameter int LFSR_W     = 16,
  parameter int NOISE_BASE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       noise_white,
  input  logic [1:0] noise_rate,
  input  logic       noise_load,
  input  logic       src_level,
  output logic       noise_out
);
  localparam int                TAP    = 3;
  localparam int                NCNT_W = $clog2((NOISE_BASE << 2) + 1);
  localparam logic [LFSR_W-1:0] SEED   = LFSR_W'(1) << (LFSR_W - 1);

  logic [LFSR_W-1:0] lfsr_q, lfsr_n;
  logic [NCNT_W-1:0] ncnt_q, ncnt_n;
  logic              src_prev_q;
  logic              fb;
  logic              src_rise;

  assign noise_out = lfsr_q[0];
  assign fb        = noise_white ? (lfsr_q[0] ^ lfsr_q[TAP]) : lfsr_q[0];
  assign src_rise  = src_level & ~src_prev_q;

  always_comb begin
    lfsr_n = lfsr_q;
    ncnt_n = ncnt_q;
    if (noise_load) begin
      lfsr_n = SEED;
      ncnt_n = '0;
    end else if (noise_rate == 2'd3) begin
      if (src_rise) lfsr_n = {fb, lfsr_q[LFSR_W-1:1]};
    end else if (tick_en) begin
      if (ncnt_q <= NCNT_W'(1)) begin
        ncnt_n = NCNT_W'(NOISE_BASE << noise_rate);
        lfsr_n = {fb, lfsr_q[LFSR_W-1:1]};
      end else begin
        ncnt_n = ncnt_q - NCNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q     <= SEED;
      ncnt_q     <= '0;
      src_prev_q <= 1'b1;
    end else begin
      lfsr_q     <= lfsr_n;
      ncnt_q     <= ncnt_n;
      src_prev_q <= src_level;
    end
  end
endmodule

// File: rtl/sqn_mix.sv
module sqn_mix #(
  parameter int ATT_W    = 4,
  parameter int LVL_W    = 8,
  parameter int SAMPLE_W = 10
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [sqn_pkg::NUM_CH-1:0]               ch_on,
  input  logic [sqn_pkg::NUM_CH-1:0][ATT_W-1:0]    att,
  output logic [SAMPLE_W-1:0]                      sample_out
);
  import sqn_pkg::*;

  localparam int NLEV = 1 << ATT_W;

  logic [LVL_W-1:0]    lvl_tab [NLEV];
  logic [SAMPLE_W-1:0] sum_n;

  for (genvar a = 0; a < NLEV; a++) begin : g_lvl
    assign lvl_tab[a] = LVL_W'(att_level(a, NLEV - 1, LVL_W));
  end

  always_comb begin
    sum_n = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_on[c]) sum_n = sum_n + SAMPLE_W'(lvl_tab[att[c]]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_out <= '0;
    else        sample_out <= sum_n;
  end
endmodule

// File: rtl/sqn_sound_gen.sv
module sqn_sound_gen #(
  parameter int PERIOD_W   = 10,
  parameter int ATT_W      = 4,
  parameter int LVL_W      = 8,
  parameter int LFSR_W     = 16,
  parameter int NOISE_BASE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [LVL_W+1:0] sample_out
);
  import sqn_pkg::*;

  localparam int SAMPLE_W = LVL_W + $clog2(NUM_CH);

  logic [NUM_TONES-1:0][PERIOD_W-1:0] period_q;
  logic [NUM_CH-1:0][ATT_W-1:0]       att_q;
  logic                               noise_white;
  logic [1:0]                         noise_rate;
  logic                               noise_load;
  logic [NUM_TONES-1:0]               tone_out;
  logic                               noise_out;

  sqn_regs #(.PERIOD_W(PERIOD_W), .ATT_W(ATT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .period_q(period_q), .att_q(att_q), .noise_white(noise_white),
    .noise_rate(noise_rate), .noise_load(noise_load)
  );

  for (genvar g = 0; g < NUM_TONES; g++) begin : g_tone
    sqn_tone #(.PERIOD_W(PERIOD_W)) u_tone (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .period(period_q[g]), .tone_out(tone_out[g])
    );
  end

  sqn_noise #(.LFSR_W(LFSR_W), .NOISE_BASE(NOISE_BASE)) u_noise (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .noise_white(noise_white), .noise_rate(noise_rate),
    .noise_load(noise_load), .src_level(tone_out[NUM_TONES-1]),
    .noise_out(noise_out)
  );

  sqn_mix #(.ATT_W(ATT_W), .LVL_W(LVL_W), .SAMPLE_W(SAMPLE_W)) u_mix (
    .clk(clk), .rst_n(rst_n), .ch_on({noise_out, tone_out}),
    .att(att_q), .sample_out(sample_out)
  );
endmodule

// File: rtl/sqn_sound_gen_chk.sv
module sqn_sound_gen_chk #(
  parameter int PERIOD_W = 10,
  parameter int ATT_W    = 4,
  parameter int LVL_W    = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick_en,
  input logic [PERIOD_W-1:0]   period0,
  input logic [4*ATT_W-1:0]    att_all,
  input logic [2:0]            tone_out,
  input logic                  noise_out,
  input logic                  noise_load,
  input logic [1:0]            noise_rate,
  input logic [LVL_W+1:0]      sample_out
);
  p_silent_mix_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (att_all == '1) |=> (sample_out == '0));

  p_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && period0 <= PERIOD_W'(1)) |=> tone_out[0]);

  p_tick_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(tone_out));

  p_seed_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    noise_load |=> !noise_out);

  p_noise_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !noise_load && noise_rate != 2'd3) |=> $stable(noise_out));
endmodule

bind sqn_sound_gen sqn_sound_gen_chk #(
  .PERIOD_W(PERIOD_W), .ATT_W(ATT_W), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .period0(period_q[0]),
  .att_all(att_q), .tone_out(tone_out), .noise_out(noise_out),
  .noise_load(noise_load), .noise_rate(noise_rate), .sample_out(sample_out)
);

// File: tb/sqn_sound_gen_bench.sv
module sqn_sound_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W      = 8;
  localparam int NB         = 4;

  logic             clk;
  logic             rst_n;
  logic             tick_en;
  logic             wr_en;
  logic [7:0]       wr_data;
  logic [LVL_W+1:0] sample_out;

  int n_checks = 0;
  int n_fail   = 0;

  int m_per [3];
  int m_cnt [3];
  bit m_out [3];
  int m_att [4];
  int m_lfsr, m_ncnt, m_rate, m_lch;
  bit m_white, m_latt, m_prev;

  sqn_sound_gen #(.NOISE_BASE(NB)) u_sqn_sound_gen (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_data(wr_data), .sample_out(sample_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int lvl(input int a);
    if (a >= 15) return 0;
    return $rtoi(255.0 * (10.0 ** (-a / 10.0)) + 0.5);
  endfunction

  task automatic check(input string tag, input int act, input int exp, input int tol);
    n_checks++;
    if (act - exp > tol || exp - act > tol) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit t, input bit w, input logic [7:0] d);
    int exp_s, tol, fb, ch;
    bit rise_prev;
    tick_en = t; wr_en = w; wr_data = d;
    @(posedge clk);
    exp_s = 0; tol = 0;
    for (int c = 0; c < 4; c++) begin
      bit on;
      on = (c < 3) ? m_out[c] : bit'(m_lfsr & 1);
      if (on) begin
        exp_s += lvl(m_att[c]);
        if (m_att[c] != 0 && m_att[c] != 15) tol++;
      end
    end
    rise_prev = m_out[2] && !m_prev;
    m_prev = m_out[2];
    for (int c = 0; c < 3; c++) begin
      if (t) begin
        if (m_per[c] <= 1) begin m_out[c] = 1; m_cnt[c] = 0; end
        else if (m_cnt[c] <= 1) begin m_cnt[c] = m_per[c]; m_out[c] = !m_out[c]; end
        else m_cnt[c]--;
      end
    end
    fb = m_white ? ((m_lfsr ^ (m_lfsr >> 3)) & 1) : (m_lfsr & 1);
    if (w && d[7] && !d[4] && d[6:5] == 2'd3) begin
      m_lfsr = 32'h8000; m_ncnt = 0;
    end else if (m_rate == 3) begin
      if (rise_prev) m_lfsr = (m_lfsr >> 1) | (fb << 15);
    end else if (t) begin
      if (m_ncnt <= 1) begin
        m_ncnt = NB << m_rate;
        m_lfsr = (m_lfsr >> 1) | (fb << 15);
      end else m_ncnt--;
    end
    if (w) begin
      if (d[7]) begin
        ch = int'(d[6:5]);
        m_lch = ch; m_latt = d[4];
        if (d[4]) m_att[ch] = int'(d[3:0]);
        else if (ch == 3) begin m_white = d[2]; m_rate = int'(d[1:0]); end
        else m_per[ch] = (m_per[ch] & 32'h3F0) | int'(d[3:0]);
      end else if (!m_latt && m_lch != 3) begin
        m_per[m_lch] = (m_per[m_lch] & 15) | (int'(d[5:0]) << 4);
      end
    end
    @(negedge clk);
    check(tag, int'(sample_out), exp_s, tol);
  endtask

  task automatic ticks(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic wr(input string tag, input logic [7:0] d);
    step(tag, 1'b1, 1'b1, d);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    for (int c = 0; c < 3; c++) begin m_per[c] = 0; m_cnt[c] = 0; m_out[c] = 1; end
    for (int c = 0; c < 4; c++) m_att[c] = 15;
    m_lfsr = 32'h8000; m_ncnt = 0; m_rate = 0; m_lch = 0;
    m_white = 0; m_latt = 0; m_prev = 1;
    repeat (3) @(negedge clk);
    check("R1", int'(sample_out), 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(sample_out), 0, 0);
    ticks("R1", 5);

    // R2 / R5: tone 0 at full volume, period 0 holds it high
    wr("R2", 8'h90);
    ticks("R5", 6);
    check("R6", int'(sample_out), 255, 0);

    // R4: period 3 via latch + data byte, with tick gaps
    wr("R2", 8'h83);
    wr("R3", 8'h00);
    ticks("R4", 30);
    for (int i = 0; i < 30; i++) step("R4", bit'(i % 3 != 0), 1'b0, 8'h00);

    // R3: data byte after attenuation latch is ignored; tone 1 period 21
    wr("R3", 8'h90);
    wr("R3", 8'h3F);
    ticks("R3", 20);
    wr("R3", 8'hA5);
    wr("R3", 8'h01);
    wr("R3", 8'hB0);
    ticks("R3", 90);
    wr("R3", 8'hE0);
    wr("R3", 8'h2A);
    ticks("R3", 20);

    // R6: levels for attenuation 3 and silence
    wr("R6", 8'hBF);
    wr("R6", 8'h80);
    wr("R6", 8'h00);
    wr("R6", 8'h93);
    ticks("R6", 4);
    check("R6", int'(sample_out), 128, 1);
    wr("R6", 8'h9F);
    ticks("R6", 3);
    check("R6", int'(sample_out), 0, 0);

    // R7: all tones held high at full volume
    wr("R7", 8'hA0); wr("R7", 8'h00);
    wr("R7", 8'hC0); wr("R7", 8'h00);
    wr("R7", 8'h90); wr("R7", 8'hB0); wr("R7", 8'hD0);
    ticks("R7", 4);
    check("R7", int'(sample_out), 765, 0);

    // Noise alone
    wr("R8", 8'h9F); wr("R8", 8'hBF); wr("R8", 8'hDF);
    wr("R8", 8'hF0);
    wr("R12", 8'hE4);
    step("R12", 1'b1, 1'b0, 8'h00);
    ticks("R8", 200);
    wr("R12", 8'hE4);
    ticks("R12", 20);
    wr("R9", 8'hE0);
    ticks("R9", 150);
    wr("R10", 8'hE5);
    for (int i = 0; i < 120; i++) step("R10", bit'(i % 4 != 0), 1'b0, 8'h00);
    wr("R10", 8'hE6);
    ticks("R10", 150);
    wr("R11", 8'hC3); wr("R11", 8'h00);
    wr("R11", 8'hE7);
    for (int i = 0; i < 200; i++) step("R11", bit'(i % 5 != 0), 1'b0, 8'h00);
    wr("R11", 8'hE3);
    ticks("R11", 100);

    // Random mix of writes and ticks
    for (int i = 0; i < 5000; i++) begin
      bit t, w;
      logic [7:0] d;
      t = ($urandom % 10) < 7;
      w = ($urandom % 8) == 0;
      d = 8'($urandom);
      if (w && d[7] == 1'b0) d[5:4] = 2'($urandom % 2);
      step("R7", t, w, d);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule